// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This unit sits at the result stage of a single-precision binary floating-point operator. It takes the two operands and works out which NaN the operation must return. Each operand is sorted as a quiet NaN, a signaling NaN or a non-NaN. A priority policy, fixed when the unit is built, picks one operand. If the chosen operand is a signaling NaN, it is made quiet before it leaves the unit.

A default-NaN control input replaces the selected value with one canonical quiet NaN. The invalid-operation flag still reports signaling operands in that mode. The arithmetic itself, rounding and the ordinary non-NaN result path are outside this unit. When neither operand is a NaN, the unit simply passes operand B through, and the surrounding datapath ignores that result.

A build parameter adds an output register. With the register, the result and the flag appear one cycle after an input strobe, together with an output valid.

Top module: `nan_select_unit`

## Requirements
- R1: An operand is a quiet NaN when bits 30:23 are all ones and bit 22 is one.
- R2: An operand is a signaling NaN when bits 30:23 are all ones, bit 22 is zero and bits 21:0 are not all zero. An infinity (all-ones exponent, zero fraction) is not a NaN.
- R3: A selected signaling NaN leaves the unit with bit 22 set. Its sign and all other bits are unchanged. A selected quiet NaN or non-NaN passes through unchanged.
- R4: invalid_o is 1 exactly when at least one operand is a signaling NaN, whether or not default mode is on.
- R5: When dflt_mode_i is 1, res_o is 0x7FC00000, whatever the operands are.
- R6: With POLICY = 0 (signal-first), the priority order is: A if signaling, then B if signaling, then A if quiet, otherwise B.
- R7: With POLICY = 1 (operand-order), the result is A if A is any NaN, otherwise B.
- R8: With POLICY = 2 (magnitude), a signaling NaN paired with a quiet NaN yields the quiet one. A lone NaN paired with a non-NaN yields that NaN.
- R9: With POLICY = 2, when both operands are NaNs of the same kind, the one with the larger value in bits 30:0 wins. If bits 30:0 are equal, the operand with sign 0 wins (B on a full tie).
- R10: When neither operand is a NaN and default mode is off, res_o equals b_i under every policy.
- R11: With OUT_REG = 1, res_o and invalid_o update on the clock edge at which valid_i is 1. valid_o equals valid_i delayed by one cycle.
- R12: While rst_ni is low, valid_o, res_o and invalid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| dflt_mode_i | input | 1 | Default-NaN mode |
| valid_o | output | 1 | Result valid |
| res_o | output | 32 | Selected (quieted) NaN or default NaN |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The assertions check four things on every cycle:
- the output valid follows the input strobe one cycle later;
- default mode always produces the canonical pattern;
- no NaN that leaves the unit is still signaling;
- when no invalid flag is raised, the result is a bit-exact copy of one of the two operands.

The picker also checks that a NaN is always chosen whenever one is present. Only the bench scenarios can show that each policy chooses the correct operand. The bench sweeps every pairing of quiet, signaling and non-NaN operands through a reference model. It also runs directed cases for significand ties, sign tie-breaks, infinities and the reset state.

// File: rtl/nan_sel_pkg.sv
package nan_sel_pkg;
  typedef enum logic [1:0] {
    POL_SIG_FIRST = 2'd0,
    POL_NAN_FIRST = 2'd1,
    POL_MAG       = 2'd2
  } nan_policy_e;

  typedef struct packed {
    logic is_nan;
    logic is_q;
    logic is_s;
  } nan_cls_t;
endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import nan_sel_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output nan_cls_t     cls_o
);
  logic exp_ones, qbit, rest_nz;

  assign exp_ones = &op_i[W-2 -: EXP_W];
  assign qbit     = op_i[FRAC_W-1];
  assign rest_nz  = |op_i[FRAC_W-2:0];

  assign cls_o.is_q   = exp_ones & qbit;
  assign cls_o.is_s   = exp_ones & ~qbit & rest_nz;
  assign cls_o.is_nan = cls_o.is_q | cls_o.is_s;

  // R1 R2: kinds are exclusive
  always_comb begin
    a_r1_kind_excl: assert (!(cls_o.is_q && cls_o.is_s));
  end
endmodule

// File: rtl/nan_pick.sv
module nan_pick
  import nan_sel_pkg::*;
#(
  parameter int          W      = 32,
  parameter nan_policy_e POLICY = POL_SIG_FIRST
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  nan_cls_t     a_cls_i,
  input  nan_cls_t     b_cls_i,
  output logic         pick_b_o
);
  generate
    if (POLICY == POL_SIG_FIRST) begin : g_sig
      always_comb begin
        if (a_cls_i.is_s)      pick_b_o = 1'b0;
        else if (b_cls_i.is_s) pick_b_o = 1'b1;
        else if (a_cls_i.is_q) pick_b_o = 1'b0;
        else                   pick_b_o = 1'b1;
      end
    end else if (POLICY == POL_NAN_FIRST) begin : g_ord
      assign pick_b_o = ~a_cls_i.is_nan;
    end else begin : g_mag
      logic a_larger;
      // magnitude excludes sign; tie favours the smaller raw code (positive sign)
      always_comb begin
        if (a_i[W-2:0] > b_i[W-2:0])      a_larger = 1'b1;
        else if (a_i[W-2:0] < b_i[W-2:0]) a_larger = 1'b0;
        else                              a_larger = (a_i < b_i);
      end
      always_comb begin
        if (a_cls_i.is_s) begin
          if (b_cls_i.is_s) pick_b_o = ~a_larger;
          else              pick_b_o = b_cls_i.is_q;
        end else if (a_cls_i.is_q) begin
          if (b_cls_i.is_q) pick_b_o = ~a_larger;
          else              pick_b_o = 1'b0;
        end else begin
          pick_b_o = 1'b1;
        end
      end
    end
  endgenerate

  // R6 R7 R8: a NaN is always chosen when one is present
  always_comb begin
    if (a_cls_i.is_nan || b_cls_i.is_nan)
      a_r8_pick_is_nan: assert (pick_b_o ? b_cls_i.is_nan : a_cls_i.is_nan);
  end
endmodule

// File: rtl/nan_quiet.sv
module nan_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  input  logic         is_s_i,
  output logic [W-1:0] op_o
);
  always_comb begin
    op_o = op_i;
    if (is_s_i) op_o[FRAC_W-1] = 1'b1;
  end
endmodule

// File: rtl/nan_select_unit.sv
module nan_select_unit
  import nan_sel_pkg::*;
#(
  parameter nan_policy_e POLICY  = POL_SIG_FIRST,
  parameter bit          OUT_REG = 1'b1,
  parameter int          EXP_W   = 8,
  parameter int          FRAC_W  = 23,
  localparam int         W       = 1 + EXP_W + FRAC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [31:0]  a_i,
  input  logic [31:0]  b_i,
  input  logic         dflt_mode_i,
  output logic         valid_o,
  output logic [31:0]  res_o,
  output logic         invalid_o
);
  localparam logic [W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] ops [2];
  nan_cls_t     cls [2];
  logic         pick_b;
  logic [W-1:0] chosen, quieted, res_d;
  logic         inv_d;

  assign ops[0] = a_i[W-1:0];
  assign ops[1] = b_i[W-1:0];

  for (genvar i = 0; i < 2; i++) begin : g_cls
    nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i (ops[i]),
      .cls_o(cls[i])
    );
  end

  nan_pick #(.W(W), .POLICY(POLICY)) u_pick (
    .a_i     (ops[0]),
    .b_i     (ops[1]),
    .a_cls_i (cls[0]),
    .b_cls_i (cls[1]),
    .pick_b_o(pick_b)
  );

  assign chosen = pick_b ? ops[1] : ops[0];

  nan_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .op_i  (chosen),
    .is_s_i(pick_b ? cls[1].is_s : cls[0].is_s),
    .op_o  (quieted)
  );

  assign res_d = dflt_mode_i ? DFLT_NAN : quieted;
  assign inv_d = cls[0].is_s | cls[1].is_s;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o   <= 1'b0;
          res_o     <= '0;
          invalid_o <= 1'b0;
        end else begin
          valid_o <= valid_i;
          if (valid_i) begin
            res_o     <= res_d;
            invalid_o <= inv_d;
          end
        end
      end

      // R11
      a_r11_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);
      a_r11_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o);
      // R5
      a_r5_dflt_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && dflt_mode_i |=> res_o == 32'h7FC0_0000);
      // R3: nothing signaling leaves the unit
      a_r3_out_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && (&res_o[30:23]) && (|res_o[22:0]) |-> res_o[22]);
      // R4: no invalid means an operand passes bit-exact
      a_r4_noinv_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && !dflt_mode_i && !(a_i[30:23] == 8'hFF && !a_i[22] && |a_i[21:0])
          && !(b_i[30:23] == 8'hFF && !b_i[22] && |b_i[21:0])
        |=> !invalid_o && (res_o == $past(a_i) || res_o == $past(b_i)));
    end else begin : g_comb
      assign valid_o   = valid_i;
      assign res_o     = res_d;
      assign invalid_o = inv_d;
    end
  endgenerate
endmodule

// File: tb/sim_nan_select_unit.sv
`timescale 1ns/1ps
module sim_nan_select_unit;
  import nan_sel_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        dflt_mode_i = 1'b0;
  logic        vld_w [3];
  logic [31:0] res_w [3];
  logic        inv_w [3];
  int          n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  for (genvar p = 0; p < 3; p++) begin : g_pol
    nan_select_unit #(.POLICY(nan_policy_e'(p)), .OUT_REG(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
      .a_i(a_i), .b_i(b_i), .dflt_mode_i(dflt_mode_i),
      .valid_o(vld_w[p]), .res_o(res_w[p]), .invalid_o(inv_w[p])
    );
  end

  localparam logic [31:0] OPS [8] = '{
    32'h7FC0_0000, 32'hFFC0_0001, 32'h7F80_0001, 32'hFF80_0005,
    32'h7FC1_2345, 32'h0000_0000, 32'h7F80_0000, 32'h3F80_0000
  };

  // {policy, a, b, dflt, expected result, expected invalid}
  localparam logic [99:0] DIR [13] = '{
    {2'd0, 32'h7FC0_0000, 32'h7F80_0001, 1'b0, 32'h7FC0_0001, 1'b1},
    {2'd1, 32'h7FC0_0000, 32'h7F80_0001, 1'b0, 32'h7FC0_0000, 1'b1},
    {2'd2, 32'h7FC0_0000, 32'h7F80_0001, 1'b0, 32'h7FC0_0000, 1'b1},
    {2'd2, 32'hFFC0_0000, 32'h7FC0_0000, 1'b0, 32'h7FC0_0000, 1'b0},
    {2'd2, 32'h7FC0_0000, 32'hFFC0_0000, 1'b0, 32'h7FC0_0000, 1'b0},
    {2'd2, 32'h7F80_0001, 32'hFF80_0005, 1'b0, 32'hFFC0_0005, 1'b1},
    {2'd2, 32'h7F80_0001, 32'hFF80_0001, 1'b0, 32'h7FC0_0001, 1'b1},
    {2'd2, 32'h3F80_0000, 32'hFFC0_0001, 1'b0, 32'hFFC0_0001, 1'b0},
    {2'd0, 32'h3F80_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},
    {2'd1, 32'h7F80_0001, 32'h0000_0000, 1'b1, 32'h7FC0_0000, 1'b1},
    {2'd0, 32'h3F80_0000, 32'hFFC0_0001, 1'b1, 32'h7FC0_0000, 1'b0},
    {2'd1, 32'h0000_0000, 32'hFF80_0005, 1'b0, 32'hFFC0_0005, 1'b1},
    {2'd1, 32'h7F80_0000, 32'h7FC1_2345, 1'b0, 32'h7FC1_2345, 1'b0}
  };

  // reference model written from the requirements
  function automatic logic [32:0] ref_model(int pol, logic [31:0] a, logic [31:0] b, logic dm);
    logic aq, as_, bq, bs, an, bn, pb, alarge;
    logic [31:0] r;
    aq  = (a[30:23] == 8'hFF) &&  a[22];                       // R1
    as_ = (a[30:23] == 8'hFF) && !a[22] && (a[21:0] != 0);     // R2
    bq  = (b[30:23] == 8'hFF) &&  b[22];
    bs  = (b[30:23] == 8'hFF) && !b[22] && (b[21:0] != 0);
    an = aq | as_;
    bn = bq | bs;
    if (a[30:0] != b[30:0]) alarge = a[30:0] > b[30:0];        // R9
    else                    alarge = !a[31] && b[31];
    case (pol)
      0: pb = as_ ? 1'b0 : bs ? 1'b1 : aq ? 1'b0 : 1'b1;        // R6
      1: pb = !an;                                              // R7
      default: begin                                            // R8
        if (as_ && bs)      pb = !alarge;
        else if (aq && bq)  pb = !alarge;
        else if (as_ && bq) pb = 1'b1;
        else if (aq && bs)  pb = 1'b0;
        else                pb = !an;
      end
    endcase
    r = pb ? b : a;
    if (pb ? bs : as_) r[22] = 1'b1;                            // R3
    if (dm) r = 32'h7FC0_0000;                                  // R5
    return {r, as_ | bs};                                       // R4
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic dm);
    @(negedge clk);
    a_i = a; b_i = b; dflt_mode_i = dm; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (2) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      chk("R12 valid", 32'(vld_w[p]), 32'h0);
      chk("R12 res", res_w[p], 32'h0);
      chk("R12 invalid", 32'(inv_w[p]), 32'h0);
    end
    rst_ni = 1'b1;

    // R11: strobe timing, result held while idle
    @(negedge clk);
    a_i = 32'h7F80_0001; b_i = 32'h0; valid_i = 1'b1;
    @(negedge clk);
    chk("R11 valid after strobe", 32'(vld_w[0]), 32'h1);
    chk("R11 result", res_w[0], 32'h7FC0_0001);
    valid_i = 1'b0; a_i = 32'h3F80_0000;
    @(negedge clk);
    chk("R11 valid drops", 32'(vld_w[0]), 32'h0);
    chk("R11 result held", res_w[0], 32'h7FC0_0001);
    chk("R11 invalid held", 32'(inv_w[0]), 32'h1);

    // sweep all operand-kind pairings through the reference (R1 R2 R3 R4 R5 R6 R7 R8 R10)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int d = 0; d < 2; d++) begin
          apply(OPS[i], OPS[j], d[0]);
          for (int p = 0; p < 3; p++) begin
            logic [32:0] e;
            e = ref_model(p, OPS[i], OPS[j], d[0]);
            chk(p == 0 ? "R6 sweep res" : p == 1 ? "R7 sweep res" : "R8 sweep res",
                res_w[p], e[32:1]);
            chk("R4 sweep invalid", 32'(inv_w[p]), 32'(e[0]));
          end
        end

    // directed corner cases with hand-derived expectations (R9 ties, R10, R5, R2 infinity)
    for (int k = 0; k < 13; k++) begin
      int p;
      p = int'(DIR[k][99:98]);
      apply(DIR[k][97:66], DIR[k][65:34], DIR[k][33]);
      chk(p == 0 ? "R6 directed" : p == 1 ? "R7 directed" : "R9 directed",
          res_w[p], DIR[k][32:1]);
      chk("R4 directed invalid", 32'(inv_w[p]), 32'(DIR[k][0]));
    end

    // R12: asynchronous reset clears outputs
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R12 async res", res_w[2], 32'h0);
    chk("R12 async valid", 32'(vld_w[2]), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule